// File: doc/BRIEF.md
# Sixteen-line select/status I/O unit

This peripheral holds sixteen single-bit output latches and watches sixteen single-bit inputs on behalf of a processor that reaches it over a narrow I/O bus. Every I/O write carries a command chosen by the least significant bit of the I/O offset. One command sets or clears a single latch. The other opens or closes a global gate that sits between all latches and the output pins. The line a command refers to is not carried in the data nibble. It is the low six bits of the processor's address bus, sampled during the access. Indices from 16 upward name lines that do not exist.

A read reports the level of the input line chosen by the index captured on the most recent I/O access, read or write. The result is a fixed 4-bit code: all ones for a high input, and 4'h7 for a low one. An out-of-range index always reads as all ones. While the gate is closed the output pins are held low, but the latches keep their contents. Reopening the gate puts all sixteen stored values back on the pins at once.

Top module: `sio16_unit`

## Requirements
- R1: After reset all sixteen latches are 0, the output gate is closed, `line_out` is 0, and the captured index is 0, so with `line_in[0]` low `io_rdata` reads 4'h7.
- R2: On an I/O write, `io_ofs` bit 0 equal to 1 selects the single-line command, and bit 0 equal to 0 selects the gate command.
- R3: A single-line write with `addr_idx` below 16 loads `io_wdata` bit 3 into the latch numbered `addr_idx`. A 1 sets the latch and a 0 clears it. No other latch changes.
- R4: A single-line write with `addr_idx` of 16 or more changes no latch, even when its low four bits name an existing line.
- R5: A gate write with `io_wdata` bit 3 equal to 1 opens the gate. From the next cycle on, `line_out` equals all sixteen latched values.
- R6: A gate write with `io_wdata` bit 3 equal to 0 closes the gate. `line_out` is then 0, and the latches keep their values, which reappear when the gate is reopened.
- R7: Single-line writes made while the gate is closed still update the latches. They become visible on `line_out` when the gate is opened.
- R8: `io_rdata` is 4'hF when the input selected by the captured index is high, and 4'h7 when it is low. It follows `line_in` combinationally.
- R9: When the captured index is 16 or more, `io_rdata` is 4'hF whatever `line_in` holds.
- R10: The captured index is loaded from `addr_idx` on every cycle with `io_wr` or `io_rd` high, and it holds otherwise. Changes of `addr_idx` without a strobe do not alter `io_rdata`.
- R11: `io_ofs` bits above bit 0 and `io_wdata` bits other than bit 3 have no effect on either command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, one access per cycle |
| io_rd | input | 1 | I/O read strobe, one access per cycle |
| io_ofs | input | 4 | I/O offset, bit 0 chooses the command |
| io_wdata | input | 4 | Write data nibble, bit 3 is the level or the gate state |
| addr_idx | input | 6 | Line index taken from the processor address bus |
| line_in | input | 16 | Input line levels |
| line_out | output | 16 | Gated output line levels |
| io_rdata | output | 4 | Status code of the selected input line |

## Verification
Single-line writes are aimed at the first line, the last line and lines in the middle. The test uses both levels, and some writes carry extra offset and data bits set, which shows that only offset bit 0 and data bit 3 are decoded. Writes at indices 16, 18, 40 and 63 catch any decoder that wraps the index to its low four bits. Closing the gate, writing while it is closed and then reopening it separates a gate on the pins from a gate that clears or freezes the latches. Reads walk a single high input across all sixteen lines, use indices beyond the last line, and move the address bus without a strobe, which shows which access the read index comes from.

// File: rtl/sio16_pkg.sv
package sio16_pkg;

  // Fixed status codes returned on a read.
  localparam logic [3:0] RD_CODE_HIGH = 4'hF;
  localparam logic [3:0] RD_CODE_LOW  = 4'h7;

  typedef enum logic {
    CMD_GATE = 1'b0,
    CMD_LINE = 1'b1
  } sio_cmd_e;

  // Offset bit 0 chooses between the two write commands.
  function automatic sio_cmd_e decode_cmd(input logic ofs_lsb);
    return ofs_lsb ? CMD_LINE : CMD_GATE;
  endfunction

  // An index names a real line only when it is below the line count.
  function automatic logic idx_in_range(input int unsigned idx,
                                        input int unsigned n_lines);
    return idx < n_lines;
  endfunction

  // Missing lines read as high.
  function automatic logic [3:0] status_code(input logic valid,
                                             input logic level);
    return (!valid || level) ? RD_CODE_HIGH : RD_CODE_LOW;
  endfunction

endpackage

// File: rtl/sio16_cmd_decode.sv
module sio16_cmd_decode
  import sio16_pkg::*;
#(
  parameter int N_LINES   = 16,
  parameter int IDX_W     = 6,
  parameter int OFS_W     = 4,
  parameter int DATA_W    = 4,
  parameter int LEVEL_BIT = 3
) (
  input  logic               io_wr,
  input  logic [OFS_W-1:0]   io_ofs,
  input  logic [DATA_W-1:0]  io_wdata,
  input  logic [IDX_W-1:0]   addr_idx,
  output logic               line_wr_ev,
  output logic               line_drop_ev,
  output logic               gate_wr_ev,
  output logic               level,
  output logic [N_LINES-1:0] line_sel
);

  sio_cmd_e cmd;
  logic     in_rng;
  logic     unused_bits;

  assign cmd          = decode_cmd(io_ofs[0]);
  assign in_rng       = idx_in_range(32'(addr_idx), N_LINES);
  assign level        = io_wdata[LEVEL_BIT];
  assign line_wr_ev   = io_wr && (cmd == CMD_LINE) && in_rng;
  assign line_drop_ev = io_wr && (cmd == CMD_LINE) && !in_rng;
  assign gate_wr_ev   = io_wr && (cmd == CMD_GATE);
  assign unused_bits  = ^{io_ofs, io_wdata};

  // One-hot line select, all zero for a missing line.
  for (genvar i = 0; i < N_LINES; i++) begin : g_sel
    assign line_sel[i] = in_rng && (addr_idx == IDX_W'(i));
  end

endmodule

// File: rtl/sio16_line_bank.sv
module sio16_line_bank #(
  parameter int N_LINES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_wr_ev,
  input  logic               gate_wr_ev,
  input  logic               level,
  input  logic [N_LINES-1:0] line_sel,
  output logic [N_LINES-1:0] latch_q,
  output logic               gate_q,
  output logic [N_LINES-1:0] line_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else if (gate_wr_ev) begin
      gate_q <= level;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[i] <= 1'b0;
      end else if (line_wr_ev && line_sel[i]) begin
        latch_q[i] <= level;
      end
    end
    assign line_out[i] = gate_q & latch_q[i];
  end

endmodule

// File: rtl/sio16_status.sv
module sio16_status
  import sio16_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [IDX_W-1:0]   addr_idx,
  input  logic [N_LINES-1:0] line_in,
  output logic [IDX_W-1:0]   idx_q,
  output logic [3:0]         io_rdata
);

  localparam int SEL_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic idx_ok;
  logic sel_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (capture) begin
      idx_q <= addr_idx;
    end
  end

  assign idx_ok    = idx_in_range(32'(idx_q), N_LINES);
  assign sel_level = idx_ok ? line_in[idx_q[SEL_W-1:0]] : 1'b1;
  assign io_rdata  = status_code(idx_ok, sel_level);

endmodule

// File: rtl/sio16_unit.sv
module sio16_unit #(
  parameter int N_LINES   = 16,
  parameter int IDX_W     = 6,
  parameter int OFS_W     = 4,
  parameter int DATA_W    = 4,
  parameter int LEVEL_BIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [OFS_W-1:0]   io_ofs,
  input  logic [DATA_W-1:0]  io_wdata,
  input  logic [IDX_W-1:0]   addr_idx,
  input  logic [N_LINES-1:0] line_in,
  output logic [N_LINES-1:0] line_out,
  output logic [3:0]         io_rdata
);

  logic               line_wr_ev;
  logic               line_drop_ev;
  logic               gate_wr_ev;
  logic               level;
  logic [N_LINES-1:0] line_sel;
  logic [N_LINES-1:0] latch_q;
  logic               gate_q;
  logic [IDX_W-1:0]   idx_q;

  sio16_cmd_decode #(
    .N_LINES(N_LINES), .IDX_W(IDX_W), .OFS_W(OFS_W),
    .DATA_W(DATA_W), .LEVEL_BIT(LEVEL_BIT)
  ) u_dec (
    .io_wr       (io_wr),
    .io_ofs      (io_ofs),
    .io_wdata    (io_wdata),
    .addr_idx    (addr_idx),
    .line_wr_ev  (line_wr_ev),
    .line_drop_ev(line_drop_ev),
    .gate_wr_ev  (gate_wr_ev),
    .level       (level),
    .line_sel    (line_sel)
  );

  sio16_line_bank #(.N_LINES(N_LINES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_wr_ev(line_wr_ev),
    .gate_wr_ev(gate_wr_ev),
    .level     (level),
    .line_sel  (line_sel),
    .latch_q   (latch_q),
    .gate_q    (gate_q),
    .line_out  (line_out)
  );

  sio16_status #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (io_wr | io_rd),
    .addr_idx(addr_idx),
    .line_in (line_in),
    .idx_q   (idx_q),
    .io_rdata(io_rdata)
  );

endmodule

// File: rtl/sio16_chk.sv
module sio16_chk #(
  parameter int N_LINES   = 16,
  parameter int IDX_W     = 6,
  parameter int OFS_W     = 4,
  parameter int DATA_W    = 4,
  parameter int LEVEL_BIT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               io_wr,
  input logic               io_rd,
  input logic [OFS_W-1:0]   io_ofs,
  input logic [DATA_W-1:0]  io_wdata,
  input logic [IDX_W-1:0]   addr_idx,
  input logic [N_LINES-1:0] line_out,
  input logic [3:0]         io_rdata,
  input logic [N_LINES-1:0] latch_q,
  input logic               line_drop_ev,
  input logic [IDX_W-1:0]   idx_q
);

  localparam int SEL_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam logic [IDX_W-1:0] N_IDX = IDX_W'(N_LINES);

  // R3: a valid single-line write lands its level in the addressed latch.
  p_line_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_ofs[0] && addr_idx < N_IDX) |=>
      latch_q[$past(addr_idx[SEL_W-1:0])] == $past(io_wdata[LEVEL_BIT]));

  // R4: a write to a missing line leaves every latch as it was.
  p_bad_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_drop_ev |=> $stable(latch_q));

  // R5: opening the gate drives every stored value out.
  p_gate_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_ofs[0] && io_wdata[LEVEL_BIT]) |=> line_out == latch_q);

  // R6: closing the gate forces the pins low.
  p_gate_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_ofs[0] && !io_wdata[LEVEL_BIT]) |=> line_out == '0);

  // R8: only the two status codes ever appear.
  p_code_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rdata == 4'hF) || (io_rdata == 4'h7));

  // R10: the read index moves only on an access.
  p_idx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr || io_rd) |=> $stable(idx_q));

endmodule

bind sio16_unit sio16_chk #(
  .N_LINES(N_LINES), .IDX_W(IDX_W), .OFS_W(OFS_W),
  .DATA_W(DATA_W), .LEVEL_BIT(LEVEL_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_ofs      (io_ofs),
  .io_wdata    (io_wdata),
  .addr_idx    (addr_idx),
  .line_out    (line_out),
  .io_rdata    (io_rdata),
  .latch_q     (latch_q),
  .line_drop_ev(line_drop_ev),
  .idx_q       (idx_q)
);

// File: tb/tb_sio16_unit.sv
module tb_sio16_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [3:0]  io_ofs = '0;
  logic [3:0]  io_wdata = '0;
  logic [5:0]  addr_idx = '0;
  logic [15:0] line_in = '0;
  logic [15:0] line_out;
  logic [3:0]  io_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  logic [15:0] m_lat;
  bit          m_on;
  int          m_idx;

  always #2 clk = ~clk;

  sio16_unit dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_ofs(io_ofs), .io_wdata(io_wdata), .addr_idx(addr_idx),
    .line_in(line_in), .line_out(line_out), .io_rdata(io_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = '0;
      m_on  = 1'b0;
      m_idx = 0;
    end else begin
      if (io_wr || io_rd) m_idx = int'(addr_idx);
      if (io_wr) begin
        if (io_ofs[0]) begin
          if (int'(addr_idx) < 16) m_lat[int'(addr_idx)] = io_wdata[3];
        end else begin
          m_on = io_wdata[3];
        end
      end
    end
  end

  function automatic logic [3:0] exp_code(int idx, logic [15:0] ins);
    if (idx >= 16) return 4'hF;
    return ins[idx] ? 4'hF : 4'h7;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("MODEL line_out R5 R6", line_out, m_on ? m_lat : 16'h0);
      check("MODEL io_rdata R8 R9", {12'h0, io_rdata},
            {12'h0, exp_code(m_idx, line_in)});
    end
  end

  task automatic acc(logic wr, logic rd, logic [3:0] ofs, logic [3:0] d,
                     logic [5:0] idx);
    io_wr = wr; io_rd = rd; io_ofs = ofs; io_wdata = d; addr_idx = idx;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset line_out", line_out, 16'h0);
    check("R1 reset rdata", {12'h0, io_rdata}, 16'h7);
    rst_n = 1'b1;
    idle();
    check("R1 idle after reset", line_out, 16'h0);

    // Open the gate with all latches cleared by reset.
    acc(1, 0, 4'h0, 4'h8, 6'd0);
    check("R1 latches clear", line_out, 16'h0);

    // Single-line sets at first, middle and last line.
    acc(1, 0, 4'h1, 4'h8, 6'd0);
    acc(1, 0, 4'h1, 4'h8, 6'd5);
    acc(1, 0, 4'h1, 4'h8, 6'd15);
    check("R3 R2 set lines", line_out, 16'h8021);
    acc(1, 0, 4'h1, 4'h7, 6'd5);
    check("R3 R11 clear line 5", line_out, 16'h8001);
    acc(1, 0, 4'h3, 4'hF, 6'd2);
    check("R2 R11 odd offset sets line 2", line_out, 16'h8005);
    acc(1, 0, 4'hE, 4'hC, 6'd9);
    check("R2 R11 even offset is gate", line_out, 16'h8005);

    // Missing lines.
    acc(1, 0, 4'h1, 4'h8, 6'd16);
    acc(1, 0, 4'h1, 4'h8, 6'd40);
    acc(1, 0, 4'h1, 4'h8, 6'd63);
    acc(1, 0, 4'h1, 4'h0, 6'd18);
    check("R4 out of range ignored", line_out, 16'h8005);

    // Close gate, write while closed, reopen.
    acc(1, 0, 4'h0, 4'h7, 6'd0);
    check("R6 gate closed", line_out, 16'h0);
    acc(1, 0, 4'h1, 4'h8, 6'd7);
    check("R7 write while closed hidden", line_out, 16'h0);
    acc(1, 0, 4'h2, 4'h8, 6'd33);
    check("R5 R6 R7 reopen", line_out, 16'h8085);

    // Reads.
    line_in = 16'h0002;
    acc(0, 1, 4'h0, 4'h0, 6'd1);
    check("R8 high input", {12'h0, io_rdata}, 16'hF);
    addr_idx = 6'd0;
    idle();
    check("R10 no strobe keeps index", {12'h0, io_rdata}, 16'hF);
    line_in = 16'h0000;
    #1;
    check("R8 follows input", {12'h0, io_rdata}, 16'h7);
    line_in = 16'hFFF7;
    acc(1, 0, 4'h0, 4'h8, 6'd3);
    check("R10 write captures index", {12'h0, io_rdata}, 16'h7);
    check("R10 gate write keeps outputs", line_out, 16'h8085);
    line_in = 16'h0000;
    acc(0, 1, 4'h0, 4'h0, 6'd20);
    check("R9 index 20", {12'h0, io_rdata}, 16'hF);
    acc(0, 1, 4'h0, 4'h0, 6'd63);
    check("R9 index 63", {12'h0, io_rdata}, 16'hF);

    for (int i = 0; i < 16; i++) begin
      line_in = 16'h1 << ((i + 1) % 16);
      acc(0, 1, 4'h0, 4'h0, 6'(i));
      check("R8 walk low", {12'h0, io_rdata}, 16'h7);
      line_in = 16'h1 << i;
      #1;
      check("R8 walk high", {12'h0, io_rdata}, 16'hF);
    end

    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule